// File: doc/BRIEF.md
# Rotating-Store Chained-Address Instruction Sequencer

This block is the control unit of a small decimal accumulator machine. Its program and its data both live in a rotating store modelled as bands of 50 word slots. A free-running slot counter advances once per word-time tick. A word can be read or written only during the tick when its slot is under the heads. The slot is the address modulo 50, and it is the same for every band.

Each instruction word carries three things: an opcode, the address of one operand, and the address of the instruction that follows. The sequencer has no increment path for its instruction address. It waits for the instruction word to come round, then waits for the operand word. It then executes for a fixed, opcode-dependent number of word times, and finally loads the instruction address from the follow-on field. Program speed therefore depends only on where the words are placed.

Two counters expose this cost: one counts word times lost to waiting and one counts word times spent executing. A preload stream fills the store while the machine is stopped. A start pulse then launches a program from a given address, and the machine runs until it fetches a halt opcode.

Top module: `drum_sequencer`

## Requirements
- R1: `drum_pos` is 0 after reset. It rises by one on each cycle with `tick` high, wraps from 49 to 0, and holds on cycles with `tick` low.
- R2: A word is 41 bits: bit 40 is the sign (1 = negative) and bits 39:0 are ten BCD digits. In an instruction word, bits 39:32 hold the opcode, bits 31:16 hold the BCD operand address and bits 15:0 hold the BCD follow-on address. The instruction word's sign is ignored. Every address is taken modulo the store depth (50 × `BANDS`).
- R3: The instruction word and the operand word at address A are each accessed only on a tick when `drum_pos` equals A mod 50.
- R4: The instruction address is never incremented. When execution ends, it is loaded from the follow-on field, so consecutive placement costs a near-full revolution per step and spaced placement costs none.
- R5: Execution takes 3 word times for opcodes 10, 15 and 20, takes 17 for opcode 60, and takes 5 for opcode 30 and for any other non-zero opcode.
- R6: Opcode 00 stops the machine and raises `halted` on the tick that fetches it. `halted`, both counters and the accumulator then hold until the next start.
- R7: Opcode 10 adds the operand to the accumulator in BCD sign-magnitude form. A zero result is positive, and a carry out of the top digit is dropped.
- R8: Opcode 15 copies the operand word into the accumulator. Opcode 20 writes the accumulator to the operand address. Opcodes 30 and 60 leave the accumulator unchanged.
- R9: `search_cnt` counts the ticks spent in either search that do not find the addressed slot. `exec_cnt` counts execution ticks. Both clear when a start is accepted. The matching access tick counts in neither.
- R10: `start` is accepted only while idle or halted, and it loads the instruction address from `start_addr`. While a program runs, `start` is ignored.
- R11: The preload stream transfers one word on each cycle where `pl_valid` and `pl_ready` are both high. `pl_ready` is high only while idle or halted. While `pl_ready` is low, the source holds `pl_valid`, `pl_addr` and `pl_data` steady, and the word is written on the first cycle that `pl_ready` returns.
- R12: After reset, `halted` is 0, `pl_ready` is 1, the accumulator is +0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One word time of rotation |
| start | input | 1 | Launch pulse |
| start_addr | input | 16 | BCD launch address |
| pl_valid | input | 1 | Preload word offered |
| pl_ready | output | 1 | Preload word accepted this cycle |
| pl_addr | input | 16 | BCD preload address |
| pl_data | input | 41 | Preload word (sign + 10 BCD digits) |
| halted | output | 1 | Machine stopped on a halt opcode |
| acc_out | output | 41 | Accumulator |
| drum_pos | output | 6 | Current slot under the heads |
| search_cnt | output | CNT_W | Word times lost waiting |
| exec_cnt | output | CNT_W | Word times spent executing |

## Verification
Single-instruction programs are run with the operand and follow-on slots placed at distances of zero, a few slots, and nearly a full turn. These placements separate slot-matching errors, off-by-one execution lengths and wrap-around mistakes in the wait counts, for each opcode class including an unassigned opcode. The same three-instruction load-add-store program is run once laid out consecutively and once spaced to match the execution times. This shows the follow-on address being used (288 versus 0 wait ticks). Operand pairs with mixed signs, equal magnitudes and a top-digit carry isolate the sign-magnitude adder. A held preload during a run and a stray start during a run show that the back-pressure and start-gating rules are kept.

// File: rtl/drum_seq_pkg.sv
`timescale 1ns/1ps
package drum_seq_pkg;
  localparam int unsigned DIGITS = 10;
  localparam int unsigned WORD_W = 4*DIGITS + 1;
  localparam int unsigned SLOTS  = 50;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_IFETCH, ST_OFETCH, ST_EXEC, ST_HALT
  } seq_state_e;

  localparam logic [7:0] OP_HALT  = 8'h00;
  localparam logic [7:0] OP_ADD   = 8'h10;
  localparam logic [7:0] OP_LOAD  = 8'h15;
  localparam logic [7:0] OP_STORE = 8'h20;
  localparam logic [7:0] OP_NOP   = 8'h30;
  localparam logic [7:0] OP_MUL   = 8'h60;

  function automatic logic [4:0] exec_len(input logic [7:0] op);
    case (op)
      OP_ADD, OP_LOAD, OP_STORE: return 5'd3;
      OP_MUL:                    return 5'd17;
      OP_NOP:                    return 5'd5;
      default:                   return 5'd5;
    endcase
  endfunction

  function automatic logic [13:0] bcd4_bin(input logic [15:0] b);
    return 14'(b[15:12]) * 14'd1000 + 14'(b[11:8]) * 14'd100
         + 14'(b[7:4]) * 14'd10 + 14'(b[3:0]);
  endfunction
endpackage

// File: rtl/drum_rotor.sv
`timescale 1ns/1ps
module drum_rotor #(
  parameter int unsigned SLOTS = 50
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  output logic [$clog2(SLOTS)-1:0] pos
);
  localparam int unsigned PW = $clog2(SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (tick)     pos <= (pos == PW'(SLOTS-1)) ? '0 : pos + PW'(1);
  end

  // R1
  rot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pos == (($past(pos) == PW'(SLOTS-1)) ? PW'(0) : $past(pos) + PW'(1)));
  // R1
  rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos));
endmodule

// File: rtl/bcd_sm_adder.sv
`timescale 1ns/1ps
module bcd_sm_adder #(
  parameter int unsigned DIGITS = 10,
  localparam int unsigned MW = 4*DIGITS
) (
  input  logic [MW:0] a,
  input  logic [MW:0] b,
  output logic [MW:0] y
);
  logic [DIGITS:0] cy, bw_ab, bw_ba;
  logic [MW-1:0]   m_sum, m_ab, m_ba, m_res;
  logic            s_res, unused_carries;

  assign cy[0]    = 1'b0;
  assign bw_ab[0] = 1'b0;
  assign bw_ba[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] da, db;
    logic [4:0] s, dab, dba;
    assign da  = a[4*g +: 4];
    assign db  = b[4*g +: 4];
    assign s   = {1'b0, da} + {1'b0, db} + {4'b0, cy[g]};
    assign cy[g+1] = s > 5'd9;
    assign m_sum[4*g +: 4] = cy[g+1] ? s[3:0] + 4'd6 : s[3:0];
    assign dab = {1'b0, da} - {1'b0, db} - {4'b0, bw_ab[g]};
    assign bw_ab[g+1] = dab[4];
    assign m_ab[4*g +: 4] = dab[4] ? dab[3:0] + 4'd10 : dab[3:0];
    assign dba = {1'b0, db} - {1'b0, da} - {4'b0, bw_ba[g]};
    assign bw_ba[g+1] = dba[4];
    assign m_ba[4*g +: 4] = dba[4] ? dba[3:0] + 4'd10 : dba[3:0];
  end

  assign unused_carries = cy[DIGITS] ^ bw_ba[DIGITS];

  always_comb begin
    if (a[MW] == b[MW]) begin
      m_res = m_sum;  s_res = a[MW];
    end else if (!bw_ab[DIGITS]) begin
      m_res = m_ab;   s_res = a[MW];
    end else begin
      m_res = m_ba;   s_res = b[MW];
    end
    y = {s_res && (m_res != '0), m_res};
  end
endmodule

// File: rtl/drum_store.sv
`timescale 1ns/1ps
module drum_store #(
  parameter int unsigned DEPTH = 1000,
  parameter int unsigned W     = 41,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/drum_sequencer.sv
`timescale 1ns/1ps
module drum_sequencer
  import drum_seq_pkg::*;
#(
  parameter int unsigned BANDS = 20,
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [15:0]       start_addr,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [15:0]       pl_addr,
  input  logic [WORD_W-1:0] pl_data,
  output logic              halted,
  output logic [WORD_W-1:0] acc_out,
  output logic [SLOT_W-1:0] drum_pos,
  output logic [CNT_W-1:0]  search_cnt,
  output logic [CNT_W-1:0]  exec_cnt
);
  localparam int unsigned DEPTH = BANDS * SLOTS;
  localparam int unsigned AW    = $clog2(DEPTH);

  seq_state_e        state;
  logic [AW-1:0]     iar, opnd_a, next_a, rd_addr, wr_addr;
  logic [7:0]        op_q;
  logic [4:0]        remain;
  word_t             acc, rd_word, sum_word, wr_data;
  logic [SLOT_W-1:0] pos, iar_slot, opnd_slot;
  logic              start_take, at_iword, at_oword, pl_take, st_we, wr_en;

  function automatic logic [AW-1:0] to_idx(input logic [15:0] b);
    return AW'(bcd4_bin(b) % 14'(DEPTH));
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [AW-1:0] a);
    return SLOT_W'(a % AW'(SLOTS));
  endfunction

  drum_rotor #(.SLOTS(SLOTS)) u_rotor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pos(pos)
  );

  drum_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_word)
  );

  bcd_sm_adder #(.DIGITS(DIGITS)) u_adder (
    .a(acc), .b(rd_word), .y(sum_word)
  );

  assign iar_slot   = slot_of(iar);
  assign opnd_slot  = slot_of(opnd_a);
  assign at_iword   = (state == ST_IFETCH) && (pos == iar_slot);
  assign at_oword   = (state == ST_OFETCH) && (pos == opnd_slot);
  assign rd_addr    = (state == ST_IFETCH) ? iar : opnd_a;
  assign pl_ready   = (state == ST_IDLE) || (state == ST_HALT);
  assign start_take = start && pl_ready;
  assign pl_take    = pl_valid && pl_ready;
  assign st_we      = tick && at_oword && (op_q == OP_STORE);
  assign wr_en      = pl_take || st_we;
  assign wr_addr    = pl_take ? to_idx(pl_addr) : opnd_a;
  assign wr_data    = pl_take ? pl_data : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      iar        <= '0;
      opnd_a     <= '0;
      next_a     <= '0;
      op_q       <= OP_HALT;
      remain     <= '0;
      acc        <= '0;
      search_cnt <= '0;
      exec_cnt   <= '0;
    end else if (start_take) begin
      state      <= ST_IFETCH;
      iar        <= to_idx(start_addr);
      search_cnt <= '0;
      exec_cnt   <= '0;
    end else if (tick) begin
      case (state)
        ST_IFETCH: begin
          if (at_iword) begin
            op_q   <= rd_word[39:32];
            opnd_a <= to_idx(rd_word[31:16]);
            next_a <= to_idx(rd_word[15:0]);
            state  <= (rd_word[39:32] == OP_HALT) ? ST_HALT : ST_OFETCH;
          end else begin
            search_cnt <= search_cnt + CNT_W'(1);
          end
        end
        ST_OFETCH: begin
          if (at_oword) begin
            if (op_q == OP_ADD)  acc <= sum_word;
            if (op_q == OP_LOAD) acc <= rd_word;
            remain <= exec_len(op_q);
            state  <= ST_EXEC;
          end else begin
            search_cnt <= search_cnt + CNT_W'(1);
          end
        end
        ST_EXEC: begin
          exec_cnt <= exec_cnt + CNT_W'(1);
          if (remain == 5'd1) begin
            iar   <= next_a;
            state <= ST_IFETCH;
          end else begin
            remain <= remain - 5'd1;
          end
        end
        default: ;
      endcase
    end
  end

  assign halted   = (state == ST_HALT);
  assign acc_out  = acc;
  assign drum_pos = pos;

  // R3
  ifetch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFETCH && $past(state) == ST_IFETCH) |-> $past(pos) == $past(iar_slot));
  // R3
  ofetch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && $past(state) == ST_OFETCH) |-> $past(pos) == $past(opnd_slot));
  // R4
  iar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(iar) |-> ($past(state) == ST_EXEC || $past(start_take)));
  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> halted && $stable(search_cnt) && $stable(exec_cnt) && $stable(acc));
  // R9
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(search_cnt) && $stable(exec_cnt));
  // R8
  acc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_OFETCH) |=> $stable(acc));
endmodule

// File: tb/drum_sequencer_bench.sv
`timescale 1ns/1ps
module drum_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n, tick, start, pl_valid, pl_ready, halted;
  logic [15:0] start_addr, pl_addr;
  logic [40:0] pl_data, acc_out;
  logic [5:0]  drum_pos;
  logic [31:0] search_cnt, exec_cnt;
  int          mirror;
  int          tests = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  drum_sequencer u_drum_sequencer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .start_addr(start_addr),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_addr(pl_addr), .pl_data(pl_data),
    .halted(halted), .acc_out(acc_out), .drum_pos(drum_pos),
    .search_cnt(search_cnt), .exec_cnt(exec_cnt)
  );

  // word-time tick every second clock; mirror models R1 from the requirement
  always @(posedge clk) begin
    if (!rst_n) begin
      tick <= 1'b0; mirror <= 0;
    end else begin
      tick <= ~tick;
      if (tick) mirror <= (mirror == 49) ? 0 : mirror + 1;
    end
  end

  // columns: opcode, instr addr, operand addr, follow-on addr, exp search, exp exec
  localparam int VEC [7][6] = '{
    '{'h10,   0,   1,   5,  0,  3},
    '{'h10,  10,  61,  11, 46,  3},
    '{'h30,  20,  21,  27,  0,  5},
    '{'h60,  30,  40,  35, 36, 17},
    '{'h15,  45, 199,   2, 52,  3},
    '{'h20, 100, 150, 104, 49,  3},
    '{'h45, 250, 251, 257,  0,  5}
  };

  task automatic chk(input string tag, input longint got, input longint exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] bcd4(input int v);
    logic [15:0] r;
    for (int i = 0; i < 4; i++) begin r[4*i +: 4] = 4'(v % 10); v = v / 10; end
    return r;
  endfunction

  function automatic logic [40:0] mk_val(input bit neg, input longint mag);
    logic [39:0] r;
    for (int i = 0; i < 10; i++) begin r[4*i +: 4] = 4'(mag % 10); mag = mag / 10; end
    return {neg, r};
  endfunction

  function automatic logic [40:0] mk_ins(input bit sgn, input logic [7:0] op,
                                         input int d, input int n);
    return {sgn, op, bcd4(d), bcd4(n)};
  endfunction

  task automatic pl_write(input int addr, input logic [40:0] data);
    @(negedge clk);
    pl_valid = 1'b1; pl_addr = bcd4(addr); pl_data = data;
    while (!pl_ready) @(negedge clk);
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  task automatic kick(input int addr);
    @(negedge clk);
    while (!(tick == 1'b0 && mirror == addr % 50)) @(negedge clk);
    start = 1'b1; start_addr = bcd4(addr);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_halt();
    int guard = 0;
    while (!halted && guard < 20000) begin @(negedge clk); guard++; end
    if (!halted) chk("R6 run did not halt", 0, 1);
  endtask

  task automatic run(input int addr);
    kick(addr);
    wait_halt();
  endtask

  task automatic bcd_case(input bit na, input longint ma, input bit nb, input longint mb,
                          input bit ne, input longint me, input string tag);
    pl_write(601, mk_val(na, ma));
    pl_write(606, mk_val(nb, mb));
    run(600);
    chk(tag, acc_out, mk_val(ne, me));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0;
    pl_valid = 1'b0; pl_addr = '0; pl_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 halted", halted, 0);
    chk("R12 pl_ready", pl_ready, 1);
    chk("R12 acc", acc_out, 0);
    chk("R12 search_cnt", search_cnt, 0);
    chk("R12 exec_cnt", exec_cnt, 0);
    chk("R1 reset pos", drum_pos, 0);

    // R1 wrap from 49 to 0
    while (!(mirror == 49 && tick == 1'b1)) @(negedge clk);
    @(negedge clk);
    chk("R1 wrap", drum_pos, 0);
    @(negedge clk);
    chk("R1 hold without tick", drum_pos, 0);

    // R3 R4 R5 R9: single instruction placements
    for (int i = 0; i < 7; i++) begin
      pl_write(VEC[i][1], mk_ins(1'b0, 8'(VEC[i][0]), VEC[i][2], VEC[i][3]));
      pl_write(VEC[i][2], mk_val(1'b0, 3));
      pl_write(VEC[i][3], '0);
      run(VEC[i][1]);
      chk($sformatf("R3 R9 row %0d search", i), search_cnt, VEC[i][4]);
      chk($sformatf("R5 R9 row %0d exec", i), exec_cnt, VEC[i][5]);
    end
    chk("R1 pos tracks ticks", drum_pos, mirror);

    // R4: consecutive layout, load 25, add 17, store to 302
    pl_write(200, mk_ins(1'b0, 8'h15, 300, 201));
    pl_write(201, mk_ins(1'b0, 8'h10, 301, 202));
    pl_write(202, mk_ins(1'b0, 8'h20, 302, 203));
    pl_write(203, '0);
    pl_write(300, mk_val(1'b0, 25));
    pl_write(301, mk_val(1'b0, 17));
    run(200);
    chk("R4 consecutive search", search_cnt, 288);
    chk("R4 consecutive exec", exec_cnt, 9);
    chk("R7 consecutive acc", acc_out, mk_val(1'b0, 42));

    // R4: spaced layout of the same program, store to 411
    pl_write(400, mk_ins(1'b0, 8'h15, 401, 405));
    pl_write(405, mk_ins(1'b0, 8'h10, 406, 410));
    pl_write(410, mk_ins(1'b0, 8'h20, 411, 415));
    pl_write(415, '0);
    pl_write(401, mk_val(1'b0, 25));
    pl_write(406, mk_val(1'b0, 17));
    run(400);
    chk("R4 spaced search", search_cnt, 0);
    chk("R4 spaced exec", exec_cnt, 9);

    // R6: halt holds
    repeat (20) @(negedge clk);
    chk("R6 halted holds", halted, 1);
    chk("R6 search holds", search_cnt, 0);
    chk("R6 exec holds", exec_cnt, 9);

    // R8: store landed at 411; load 1 then reload 411
    pl_write(500, mk_ins(1'b0, 8'h15, 501, 505));
    pl_write(501, mk_val(1'b0, 1));
    pl_write(505, mk_ins(1'b0, 8'h15, 411, 510));
    pl_write(510, '0);
    run(500);
    chk("R8 store then load", acc_out, mk_val(1'b0, 42));

    // R8 R5: multiply and no-op leave acc
    pl_write(720, mk_ins(1'b0, 8'h15, 721, 725));
    pl_write(721, mk_val(1'b0, 8));
    pl_write(725, mk_ins(1'b0, 8'h60, 726, 744));
    pl_write(726, mk_val(1'b0, 9));
    pl_write(744, mk_ins(1'b0, 8'h30, 745, 751));
    pl_write(745, mk_val(1'b0, 4));
    pl_write(751, '0);
    run(720);
    chk("R8 mul/nop acc", acc_out, mk_val(1'b0, 8));
    chk("R5 mul/nop exec", exec_cnt, 25);
    chk("R5 mul/nop search", search_cnt, 0);

    // R7 adder cases
    pl_write(600, mk_ins(1'b0, 8'h15, 601, 605));
    pl_write(605, mk_ins(1'b0, 8'h10, 606, 610));
    pl_write(610, '0);
    bcd_case(1'b0, 5, 1'b1, 12, 1'b1, 7, "R7 +5 + -12");
    bcd_case(1'b0, 64'd9999999999, 1'b0, 1, 1'b0, 0, "R7 overflow drop");
    bcd_case(1'b0, 5, 1'b1, 5, 1'b0, 0, "R7 positive zero");
    bcd_case(1'b1, 25, 1'b1, 17, 1'b1, 42, "R7 both negative");
    bcd_case(1'b0, 123, 1'b0, 877, 1'b0, 1000, "R7 decimal carry");

    // R2: operand address 1005 wraps to 5, instruction sign ignored
    pl_write(5, mk_val(1'b0, 77));
    pl_write(700, mk_ins(1'b1, 8'h15, 1005, 705));
    pl_write(705, '0);
    run(700);
    chk("R2 address wrap", acc_out, mk_val(1'b0, 77));

    // R10: stray start during a run is ignored
    kick(400);
    repeat (6) @(negedge clk);
    start = 1'b1; start_addr = bcd4(10);
    @(negedge clk);
    start = 1'b0;
    wait_halt();
    chk("R10 stray start search", search_cnt, 0);
    chk("R10 stray start exec", exec_cnt, 9);

    // R11: preload held while running, lands once halted
    kick(200);
    @(negedge clk);
    pl_valid = 1'b1; pl_addr = bcd4(801); pl_data = mk_val(1'b0, 333);
    repeat (3) @(negedge clk);
    chk("R11 ready low while running", pl_ready, 0);
    wait_halt();
    chk("R11 ready back at halt", pl_ready, 1);
    @(negedge clk);
    pl_valid = 1'b0;
    pl_write(850, mk_ins(1'b0, 8'h15, 801, 855));
    pl_write(855, '0);
    run(850);
    chk("R11 held word written", acc_out, mk_val(1'b0, 333));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule